// File: doc/BRIEF.md
# Cartridge Header Checker and Classifier

This block watches a cartridge image as it streams in, one byte per accepted cycle, starting at image offset 0. It keeps only what it needs from the 336-byte header window: the controller type code (offset 0x147), the ROM size code (0x148), the RAM size code (0x149) and the stored header checksum (0x14D). While the bytes pass, it folds a running checksum over offsets 0x134 to 0x14C. Once the byte at offset 0x14F has been accepted, it reports a classification: the controller class, the ROM and RAM bank counts, whether the RAM is battery backed, whether the checksum disagreed, and an error code.

A loader uses the report to decide whether and how the rest of the image can be mapped. A checksum disagreement is only a warning and never rejects the image. Every byte after the header is ignored until the next synchronous reset.

The control is a three-state machine. `ST_STREAM` accepts header bytes. The transition LAST_BYTE, taken when offset 0x14F is accepted, moves it to `ST_REPORT`, which lasts one cycle and raises `res_valid`. The transition REPORT_DONE then moves it, unconditionally, to `ST_DONE`. It stays in `ST_DONE` until reset and keeps the result fields steady there.

Top module: `cart_hdr_classifier`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `res_valid` is 0. Only cycles with `byte_valid` high advance the offset. `res_valid` is high for exactly the one cycle that follows the clock edge that accepted the byte at offset 0x14F.
- R2: The checksum starts at 0. Each accepted byte at offsets 0x134..0x14C updates it to (checksum - byte - 1) mod 256. `res_sum_bad` is 1 when the result differs from the byte at 0x14D. A mismatch never changes `res_err`, `res_class` or the counts.
- R3: ROM size codes 0..8 mean 2<<code banks. In the two banked classes, any other ROM size code gives `res_err`=3 (bad ROM code).
- R4: RAM size codes map to bank counts as follows: 0→0, 1→1, 2→1, 3→4, 4→16, 5→8. Any other code is unrecognised. For a banked type with RAM, an unrecognised code gives `res_err`=5.
- R5: Type codes 0, 8 and 9 give `res_class`=0 (ROM only) with 2 ROM banks and no error, whatever the size codes hold. They have 0 RAM banks for type 0 and 1 RAM bank for types 8 and 9. The battery flag is set for type 9 only.
- R6: Type codes 1..3 give `res_class`=1 (banked). Type 1 always has 0 RAM banks, and its RAM code is never checked. Types 2 and 3 accept RAM counts 0, 1 or 4; any other decoded count gives `res_err`=6. The battery flag is set for type 3.
- R7: Type codes 0x0F..0x13 give `res_class`=2 (banked with clock). Types 0x0F and 0x11 have 0 RAM banks and their RAM code is never checked. Types 0x10, 0x12 and 0x13 accept RAM counts of only 1 or 4; any other count, including 0, gives `res_err`=6. The battery flag is set for 0x10 and 0x13.
- R8: Type codes 5, 6, 0x0B..0x0D, 0x19..0x1E, 0x20, 0x22 and 0xFC..0xFF give `res_err`=1 (unsupported). Every other unlisted code gives `res_err`=2 (unknown). Both give `res_class`=3 (none).
- R9: Bytes offered after offset 0x14F produce no further `res_valid` pulse and leave every result field unchanged until reset.
- R10: In the banked classes, a ROM count above 128 gives `res_err`=4. ROM checks take priority over RAM checks. Whenever `res_err` is not 0, both counts and the battery flag read 0.
- R11: After the pulse, all result fields hold their values on every cycle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Image byte offered this cycle |
| byte_data | input | 8 | Image byte |
| res_valid | output | 1 | One-cycle result pulse |
| res_class | output | 2 | 0 ROM only, 1 banked, 2 banked with clock, 3 none |
| res_rom_cnt | output | 10 | ROM bank count (16 KiB banks) |
| res_ram_cnt | output | 5 | RAM bank count (8 KiB banks) |
| res_battery | output | 1 | RAM is battery backed |
| res_sum_bad | output | 1 | Header checksum disagreed |
| res_err | output | 3 | 0 ok, 1 unsupported type, 2 unknown type, 3 bad ROM code, 4 ROM too large, 5 bad RAM code, 6 RAM count not allowed |

## Verification
The result fields come from registers through combinational decode only, so they are due in the same cycle as `res_valid`. That is one cycle after the clock edge that accepts offset 0x14F, however many idle cycles were inserted along the way. The bench model counts the accepted bytes at each rising edge and predicts the pulse cycle. The outputs are compared at every falling edge: the pulse in every cycle, and all fields on the pulse cycle and on every later cycle, including while trailing bytes are offered. Idle gaps inside the header shift the due cycle, and this exercises the requirement that only accepted bytes count.

// File: rtl/cart_hdr_pkg.sv
package cart_hdr_pkg;

    typedef enum logic [1:0] {
        CLS_ROM_ONLY   = 2'd0,
        CLS_BANKED     = 2'd1,
        CLS_BANKED_RTC = 2'd2,
        CLS_NONE       = 2'd3
    } cart_class_e;

    typedef enum logic [2:0] {
        ERR_NONE            = 3'd0,
        ERR_TYPE_UNSUPPORTED = 3'd1,
        ERR_TYPE_UNKNOWN    = 3'd2,
        ERR_ROM_CODE        = 3'd3,
        ERR_ROM_TOO_BIG     = 3'd4,
        ERR_RAM_CODE        = 3'd5,
        ERR_RAM_NOT_ALLOWED = 3'd6
    } cart_err_e;

    typedef enum logic [1:0] {
        ST_STREAM = 2'd0,
        ST_REPORT = 2'd1,
        ST_DONE   = 2'd2
    } hdr_state_e;

endpackage

// File: rtl/hdr_offset_tracker.sv
module hdr_offset_tracker #(
    parameter int HDR_LEN = 336,
    parameter int OFS_W   = $clog2(HDR_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    output logic [OFS_W-1:0] offset,
    output logic             is_last
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(HDR_LEN - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset <= '0;
        end else if (accept) begin
            offset <= offset + 1'b1;
        end
    end

    assign is_last = (offset == LAST_OFS);
endmodule

// File: rtl/hdr_field_capture.sv
module hdr_field_capture #(
    parameter int OFS_W    = 9,
    parameter int OFS_TYPE = 327,
    parameter int OFS_ROM  = 328,
    parameter int OFS_RAM  = 329,
    parameter int OFS_SUM  = 333
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [OFS_W-1:0] offset,
    input  logic [7:0]       byte_data,
    output logic [7:0]       type_code,
    output logic [7:0]       rom_code,
    output logic [7:0]       ram_code,
    output logic [7:0]       sum_stored
);
    localparam int N_FIELDS = 4;
    localparam int FIELD_OFS [N_FIELDS] = '{OFS_TYPE, OFS_ROM, OFS_RAM, OFS_SUM};

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
        logic [7:0] q_byte;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_byte <= 8'h00;
            end else if (accept && (offset == OFS_W'(FIELD_OFS[g]))) begin
                q_byte <= byte_data;
            end
        end
    end

    assign type_code  = g_fld[0].q_byte;
    assign rom_code   = g_fld[1].q_byte;
    assign ram_code   = g_fld[2].q_byte;
    assign sum_stored = g_fld[3].q_byte;
endmodule

// File: rtl/hdr_sum_fold.sv
module hdr_sum_fold #(
    parameter int OFS_W     = 9,
    parameter int SUM_FIRST = 308,
    parameter int SUM_LAST  = 332
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [OFS_W-1:0] offset,
    input  logic [7:0]       byte_data,
    output logic [7:0]       sum_acc
);
    localparam logic [OFS_W-1:0] LO = OFS_W'(SUM_FIRST);
    localparam logic [OFS_W-1:0] HI = OFS_W'(SUM_LAST);

    logic in_window;
    assign in_window = (offset >= LO) && (offset <= HI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_acc <= 8'h00;
        end else if (accept && in_window) begin
            sum_acc <= sum_acc - byte_data - 8'd1;
        end
    end
endmodule

// File: rtl/hdr_type_decode.sv
module hdr_type_decode
    import cart_hdr_pkg::*;
#(
    parameter int ROM_CNT_W      = 10,
    parameter int RAM_CNT_W      = 5,
    parameter int MAX_ROM_CODE   = 8,
    parameter int MAX_BANKED_ROM = 128
) (
    input  logic [7:0]           type_code,
    input  logic [7:0]           rom_code,
    input  logic [7:0]           ram_code,
    output cart_class_e          cls,
    output logic [ROM_CNT_W-1:0] rom_cnt,
    output logic [RAM_CNT_W-1:0] ram_cnt,
    output logic                 battery,
    output cart_err_e            err
);
    localparam logic [ROM_CNT_W-1:0] ROM_LIMIT = ROM_CNT_W'(MAX_BANKED_ROM);
    localparam logic [ROM_CNT_W-1:0] ROM_BASE  = ROM_CNT_W'(2);

    logic                 rom_ok;
    logic [ROM_CNT_W-1:0] rom_raw;
    logic                 ram_ok;
    logic [RAM_CNT_W-1:0] ram_raw;
    logic                 is_rom_only, is_banked, is_rtc, is_unsup;
    logic                 has_ram, has_bat, zero_ram_ok, ram_legal;

    assign rom_ok  = (rom_code <= 8'(MAX_ROM_CODE));
    assign rom_raw = rom_ok ? (ROM_BASE << rom_code[3:0]) : '0;

    always_comb begin
        ram_ok  = 1'b1;
        ram_raw = '0;
        case (ram_code)
            8'h00:   ram_raw = RAM_CNT_W'(0);
            8'h01:   ram_raw = RAM_CNT_W'(1);
            8'h02:   ram_raw = RAM_CNT_W'(1);
            8'h03:   ram_raw = RAM_CNT_W'(4);
            8'h04:   ram_raw = RAM_CNT_W'(16);
            8'h05:   ram_raw = RAM_CNT_W'(8);
            default: ram_ok  = 1'b0;
        endcase
    end

    assign is_rom_only = type_code inside {8'h00, 8'h08, 8'h09};
    assign is_banked   = type_code inside {[8'h01:8'h03]};
    assign is_rtc      = type_code inside {[8'h0F:8'h13]};
    assign is_unsup    = type_code inside {8'h05, 8'h06, [8'h0B:8'h0D], [8'h19:8'h1E],
                                           8'h20, 8'h22, [8'hFC:8'hFF]};

    assign has_ram     = is_banked ? (type_code != 8'h01)
                                   : (type_code inside {8'h10, 8'h12, 8'h13});
    assign has_bat     = is_banked ? (type_code == 8'h03)
                                   : (type_code inside {8'h10, 8'h13});
    assign zero_ram_ok = is_banked;
    assign ram_legal   = (ram_raw == RAM_CNT_W'(1)) || (ram_raw == RAM_CNT_W'(4)) ||
                         (zero_ram_ok && (ram_raw == RAM_CNT_W'(0)));

    always_comb begin
        cls     = CLS_NONE;
        rom_cnt = '0;
        ram_cnt = '0;
        battery = 1'b0;
        err     = ERR_TYPE_UNKNOWN;
        if (is_rom_only) begin
            cls     = CLS_ROM_ONLY;
            rom_cnt = ROM_BASE;
            ram_cnt = (type_code == 8'h00) ? RAM_CNT_W'(0) : RAM_CNT_W'(1);
            battery = (type_code == 8'h09);
            err     = ERR_NONE;
        end else if (is_banked || is_rtc) begin
            cls = is_banked ? CLS_BANKED : CLS_BANKED_RTC;
            if (!rom_ok) begin
                err = ERR_ROM_CODE;
            end else if (rom_raw > ROM_LIMIT) begin
                err = ERR_ROM_TOO_BIG;
            end else if (!has_ram) begin
                err = ERR_NONE;
            end else if (!ram_ok) begin
                err = ERR_RAM_CODE;
            end else if (ram_legal) begin
                err     = ERR_NONE;
                ram_cnt = ram_raw;
            end else begin
                err = ERR_RAM_NOT_ALLOWED;
            end
            if (err == ERR_NONE) begin
                rom_cnt = rom_raw;
                battery = has_bat;
            end
        end else if (is_unsup) begin
            err = ERR_TYPE_UNSUPPORTED;
        end
    end
endmodule

// File: rtl/cart_hdr_classifier.sv
module cart_hdr_classifier
    import cart_hdr_pkg::*;
#(
    parameter int HDR_LEN        = 336,
    parameter int SUM_FIRST      = 308,
    parameter int SUM_LAST       = 332,
    parameter int OFS_TYPE       = 327,
    parameter int OFS_ROM        = 328,
    parameter int OFS_RAM        = 329,
    parameter int OFS_SUM        = 333,
    parameter int ROM_CNT_W      = 10,
    parameter int RAM_CNT_W      = 5,
    parameter int MAX_BANKED_ROM = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    output logic                 res_valid,
    output logic [1:0]           res_class,
    output logic [ROM_CNT_W-1:0] res_rom_cnt,
    output logic [RAM_CNT_W-1:0] res_ram_cnt,
    output logic                 res_battery,
    output logic                 res_sum_bad,
    output logic [2:0]           res_err
);
    localparam int OFS_W = $clog2(HDR_LEN + 1);

    hdr_state_e           state, state_nx;
    logic                 accept, is_last;
    logic [OFS_W-1:0]     offset;
    logic [7:0]           type_code, rom_code, ram_code, sum_stored, sum_acc;
    cart_class_e          dec_cls;
    cart_err_e            dec_err;
    logic [ROM_CNT_W-1:0] dec_rom;
    logic [RAM_CNT_W-1:0] dec_ram;
    logic                 dec_bat;

    assign accept = byte_valid && (state == ST_STREAM);

    hdr_offset_tracker #(.HDR_LEN(HDR_LEN), .OFS_W(OFS_W)) u_ofs (
        .clk(clk), .rst_n(rst_n), .accept(accept), .offset(offset), .is_last(is_last)
    );

    hdr_field_capture #(
        .OFS_W(OFS_W), .OFS_TYPE(OFS_TYPE), .OFS_ROM(OFS_ROM),
        .OFS_RAM(OFS_RAM), .OFS_SUM(OFS_SUM)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .accept(accept), .offset(offset),
        .byte_data(byte_data), .type_code(type_code), .rom_code(rom_code),
        .ram_code(ram_code), .sum_stored(sum_stored)
    );

    hdr_sum_fold #(.OFS_W(OFS_W), .SUM_FIRST(SUM_FIRST), .SUM_LAST(SUM_LAST)) u_sum (
        .clk(clk), .rst_n(rst_n), .accept(accept), .offset(offset),
        .byte_data(byte_data), .sum_acc(sum_acc)
    );

    hdr_type_decode #(
        .ROM_CNT_W(ROM_CNT_W), .RAM_CNT_W(RAM_CNT_W), .MAX_BANKED_ROM(MAX_BANKED_ROM)
    ) u_dec (
        .type_code(type_code), .rom_code(rom_code), .ram_code(ram_code),
        .cls(dec_cls), .rom_cnt(dec_rom), .ram_cnt(dec_ram),
        .battery(dec_bat), .err(dec_err)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STREAM;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: LAST_BYTE (STREAM->REPORT), REPORT_DONE (REPORT->DONE)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STREAM: if (accept && is_last) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_DONE;
            default:   state_nx = ST_STREAM;
        endcase
    end

    // Outputs
    always_comb begin
        res_valid   = (state == ST_REPORT);
        res_class   = dec_cls;
        res_rom_cnt = dec_rom;
        res_ram_cnt = dec_ram;
        res_battery = dec_bat;
        res_sum_bad = (sum_acc != sum_stored);
        res_err     = dec_err;
    end
endmodule

// File: rtl/cart_hdr_checker.sv
module cart_hdr_checker
    import cart_hdr_pkg::*;
#(
    parameter int ROM_CNT_W = 10,
    parameter int RAM_CNT_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 res_valid,
    input logic [1:0]           res_class,
    input logic [ROM_CNT_W-1:0] res_rom_cnt,
    input logic [RAM_CNT_W-1:0] res_ram_cnt,
    input logic                 res_battery,
    input logic                 res_sum_bad,
    input logic [2:0]           res_err
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         seen_q <= 1'b0;
        else if (res_valid) seen_q <= 1'b1;
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R1

    AST_SINGLE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> !res_valid); // R9

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> $stable({res_class, res_rom_cnt, res_ram_cnt, res_battery, res_sum_bad, res_err})); // R11

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err != ERR_NONE) |->
        (res_rom_cnt == '0 && res_ram_cnt == '0 && !res_battery)); // R10

    AST_ROMONLY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == CLS_ROM_ONLY) |->
        (res_err == ERR_NONE && res_rom_cnt == ROM_CNT_W'(2) && res_ram_cnt <= RAM_CNT_W'(1))); // R5

    AST_ROM_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err == ERR_NONE) |-> ($countones(res_rom_cnt) == 1)); // R3

    AST_BANKED_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == CLS_BANKED && res_err == ERR_NONE) |->
        (res_ram_cnt == RAM_CNT_W'(0) || res_ram_cnt == RAM_CNT_W'(1) || res_ram_cnt == RAM_CNT_W'(4))); // R6

    AST_RTC_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == CLS_BANKED_RTC && res_err == ERR_NONE) |->
        (res_ram_cnt == RAM_CNT_W'(0) || res_ram_cnt == RAM_CNT_W'(1) || res_ram_cnt == RAM_CNT_W'(4))); // R7

    AST_TYPE_ERR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_err == ERR_TYPE_UNSUPPORTED || res_err == ERR_TYPE_UNKNOWN)) |->
        (res_class == CLS_NONE)); // R8
endmodule

bind cart_hdr_classifier cart_hdr_checker #(.ROM_CNT_W(ROM_CNT_W), .RAM_CNT_W(RAM_CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_class(res_class),
    .res_rom_cnt(res_rom_cnt), .res_ram_cnt(res_ram_cnt), .res_battery(res_battery),
    .res_sum_bad(res_sum_bad), .res_err(res_err)
);

// File: tb/cart_hdr_classifier_bench.sv
`timescale 1ns/1ps
module cart_hdr_classifier_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       res_valid, res_battery, res_sum_bad;
    logic [1:0] res_class;
    logic [9:0] res_rom_cnt;
    logic [4:0] res_ram_cnt;
    logic [2:0] res_err;

    always #2.5 clk = ~clk;

    cart_hdr_classifier u_cart_hdr_classifier (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .res_valid(res_valid), .res_class(res_class), .res_rom_cnt(res_rom_cnt),
        .res_ram_cnt(res_ram_cnt), .res_battery(res_battery),
        .res_sum_bad(res_sum_bad), .res_err(res_err)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] hdr [336];
    int e_cls, e_rom, e_ram, e_bat, e_bad, e_err;
    string cur_tag = "R1";

    // Behavioural model of the pulse timing
    int m_cnt = 0;
    bit m_done = 0, m_live = 0, exp_valid = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; exp_valid = 0; m_live = 1;
        end else begin
            exp_valid = 0;
            if (!m_done && byte_valid) begin
                if (m_cnt == 335) begin exp_valid = 1; m_done = 1; end
                m_cnt++;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_fields(string tag);
        chk(tag, "class", int'(res_class), e_cls);
        chk(tag, "rom_cnt", int'(res_rom_cnt), e_rom);
        chk(tag, "ram_cnt", int'(res_ram_cnt), e_ram);
        chk(tag, "battery", int'(res_battery), e_bat);
        chk(tag, "err", int'(res_err), e_err);
        chk("R2", "sum_bad", int'(res_sum_bad), e_bad);
    endtask

    always @(negedge clk) begin
        if (m_live && !finished) begin
            chk((m_done && !exp_valid) ? "R9" : "R1", "res_valid", int'(res_valid), int'(exp_valid));
            if (exp_valid)   cmp_fields(cur_tag);
            else if (m_done) cmp_fields("R11");
        end
    end

    function automatic void ref_eval();
        int t, r, m, rb, rm, s;
        bit need_ram, zero_ok, bat;
        t = hdr[327]; r = hdr[328]; m = hdr[329];
        s = 0;
        for (int i = 308; i <= 332; i++) s = (s - hdr[i] - 1) & 255;
        e_bad = (s != hdr[333]);
        rb = (r <= 8) ? (2 << r) : -1;
        case (m)
            0: rm = 0;  1: rm = 1;  2: rm = 1;
            3: rm = 4;  4: rm = 16; 5: rm = 8;
            default: rm = -1;
        endcase
        e_cls = 3; e_rom = 0; e_ram = 0; e_bat = 0; e_err = 2;
        if (t == 0 || t == 8 || t == 9) begin
            e_cls = 0; e_rom = 2; e_ram = (t != 0); e_bat = (t == 9); e_err = 0;
        end else if ((t >= 1 && t <= 3) || (t >= 15 && t <= 19)) begin
            e_cls    = (t <= 3) ? 1 : 2;
            need_ram = (t <= 3) ? (t != 1) : (t == 16 || t == 18 || t == 19);
            bat      = (t <= 3) ? (t == 3) : (t == 16 || t == 19);
            zero_ok  = (t <= 3);
            if (rb < 0)                                  e_err = 3;
            else if (rb > 128)                           e_err = 4;
            else if (!need_ram)                          e_err = 0;
            else if (rm < 0)                             e_err = 5;
            else if (rm == 1 || rm == 4 || (rm == 0 && zero_ok)) begin e_err = 0; e_ram = rm; end
            else                                         e_err = 6;
            if (e_err == 0) begin e_rom = rb; e_bat = bat; end
        end else if (t == 5 || t == 6 || (t >= 11 && t <= 13) || (t >= 25 && t <= 30) ||
                     t == 32 || t == 34 || t >= 252) begin
            e_err = 1;
        end
    endfunction

    task automatic run_case(int t, int r, int m, bit good, string tag, bit chk_reset);
        int s;
        @(negedge clk); rst_n = 0; byte_valid = 0;
        repeat (2) @(negedge clk);
        if (chk_reset) chk("R1", "reset res_valid", int'(res_valid), 0);
        rst_n = 1;
        for (int i = 0; i < 336; i++) hdr[i] = 8'((i * 37) + (t * 11) + 5);
        hdr[327] = 8'(t); hdr[328] = 8'(r); hdr[329] = 8'(m);
        s = 0;
        for (int i = 308; i <= 332; i++) s = (s - hdr[i] - 1) & 255;
        hdr[333] = good ? 8'(s) : 8'(s ^ 8'h5A);
        ref_eval();
        cur_tag = tag;
        for (int i = 0; i < 336; i++) begin
            if (i % 13 == 5) begin @(negedge clk); byte_valid = 0; end
            @(negedge clk); byte_valid = 1; byte_data = hdr[i];
        end
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); byte_valid = 1; byte_data = 8'($urandom);
        end
        @(negedge clk); byte_valid = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        run_case(8'h00, 0, 0, 1, "R5", 1);
        run_case(8'h09, 5, 3, 0, "R2", 0);
        run_case(8'h08, 8'h52, 8'hAA, 1, "R5", 0);
        run_case(8'h03, 6, 3, 1, "R6", 0);
        run_case(8'h01, 2, 4, 1, "R6", 0);
        run_case(8'h02, 7, 2, 1, "R10", 0);
        run_case(8'h02, 8'h53, 9, 1, "R10", 0);
        run_case(8'h03, 1, 4, 0, "R6", 0);
        run_case(8'h02, 1, 7, 1, "R4", 0);
        run_case(8'h02, 0, 0, 1, "R6", 0);
        run_case(8'h13, 3, 1, 1, "R7", 0);
        run_case(8'h10, 0, 0, 1, "R7", 0);
        run_case(8'h11, 4, 8'hFF, 1, "R7", 0);
        run_case(8'h12, 2, 5, 1, "R4", 0);
        run_case(8'h0F, 8, 2, 1, "R3", 0);
        run_case(8'h12, 9, 2, 1, "R3", 0);
        run_case(8'h1B, 0, 0, 1, "R8", 0);
        run_case(8'hFE, 0, 0, 1, "R8", 0);
        run_case(8'h04, 0, 0, 1, "R8", 0);
        run_case(8'h0E, 0, 0, 1, "R8", 0);
        for (int t = 0; t < 256; t++)
            run_case(t, (t * 3) % 11, (t * 5) % 7, (t % 3) != 0, "R8", 0);
        finish_sim();
    end
endmodule